// File: doc/BRIEF.md
# Dual-Rail Handshake Register Pipeline

This block is a two-stage dual-rail register pipeline. Each bit of a word travels on a true rail and a false rail; both rails low means the bit is empty (NULL), exactly one rail high means the bit carries a value (DATA). A stage latches a DATA word only while its downstream request line asks for data, and it latches a NULL word only while that line asks for null. Each bit reports its own emptiness. A completion unit watches all of these reports and flips a single request line back to the producer only when the whole word has changed.

The storage elements are modelled as 2-of-2 hysteresis gates. Each gate is updated on a free-running sampling clock, so the block can live inside a synchronous code base. A producer drives a DATA word, waits for the request line to fall, then drives NULL and waits for the line to rise. A consumer grants data or null through its own request input. Between the two stages sits a plain dual-rail pass-through path.

Top module: `ncl_dr_pipe`

## Requirements
- R1: While reset is asserted and on the first sample after it, every output rail (`snk_t`, `snk_f`) is 0 (NULL) and `src_ko` is 1 (request for data).
- R2: While `snk_ki` is 0 (request for null), a word launched by the producer never reaches an empty output bit: every output bit stays NULL.
- R3: While `snk_ki` is 1 (request for data), an output bit that holds DATA keeps its value, even after the producer has returned to NULL.
- R4: A bit is DATA 1 when its true rail is 1 and its false rail is 0. It is DATA 0 when the false rail is 1 and the true rail is 0. Each bit reports empty (1) exactly when both of its rails are 0.
- R5: A request line falls only after every bit of the watched word is DATA, and rises only after every bit is NULL. For a partial word it holds its previous value.
- R6: Every DATA word delivered at the sink equals the word the producer launched, in launch order, and one delivery happens per launched word.
- R7: Between two DATA words the sink output passes through an all-NULL word. While a word is held, each bit either keeps its captured value or is NULL.
- R8: For legal input words, no output bit ever has both rails at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the hysteresis state |
| rst_n | input | 1 | Active-low reset; clears all rails to NULL |
| src_t | input | W | Producer true rails |
| src_f | input | W | Producer false rails |
| src_ko | output | W=1 | Request to producer: 1 asks for data, 0 asks for null |
| snk_t | output | W | Sink true rails |
| snk_f | output | W | Sink false rails |
| snk_ki | input | 1 | Consumer request: 1 grants data, 0 grants null |

## Verification
The hardest state to reach from the ports is a half-changed word. In that state some bits have switched and others have not, and the completion units must hold their request line. The stimulus drives half a word of DATA, and later half a word of NULL, and holds each for many samples before completing it. It also withholds the consumer grant, so the first stage fills while the second must stay empty, and the second must keep DATA while the first drains to NULL.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

    // 2-of-2 hysteresis gate: set when both inputs are high, clear when both are low.
    function automatic logic th22_next(input logic a, input logic b, input logic q);
        return (a & b) | (q & (a | b));
    endfunction

    // Hysteresis completion: rise on all ones, fall on all zeros, else keep.
    function automatic logic hyst_next(input logic all_one, input logic all_zero, input logic q);
        return all_one ? 1'b1 : (all_zero ? 1'b0 : q);
    endfunction

endpackage

// File: rtl/ncl_reg_stage.sv
module ncl_reg_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ki,
    input  logic [W-1:0] din_t,
    input  logic [W-1:0] din_f,
    output logic [W-1:0] dout_t,
    output logic [W-1:0] dout_f,
    output logic [W-1:0] ko_bits
);
    import ncl_pkg::*;

    typedef struct packed {
        logic [W-1:0] t;
        logic [W-1:0] f;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            st_d.t[i] = th22_next(din_t[i], ki, st_q.t[i]);
            st_d.f[i] = th22_next(din_f[i], ki, st_q.f[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_t  = st_q.t;
    assign dout_f  = st_q.f;
    assign ko_bits = ~(st_q.t | st_q.f);

    for (genvar g = 0; g < W; g++) begin : g_bit_chk
        // R2
        null_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ki && !st_q.t[g] && !st_q.f[g]) |=> (!st_q.t[g] && !st_q.f[g]));
        // R3
        data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ki && (st_q.t[g] || st_q.f[g]) && !(din_t[g] && din_f[g]))
            |=> $stable({st_q.t[g], st_q.f[g]}));
    end

endmodule

// File: rtl/ncl_compl_tree.sv
module ncl_compl_tree #(
    parameter int W   = 16,
    parameter int GRP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ko_bits,
    output logic         ko
);
    import ncl_pkg::*;

    localparam int NGRP = (W + GRP - 1) / GRP;
    localparam int PADW = NGRP * GRP;

    typedef struct packed {
        logic [NGRP-1:0] grp;
        logic            root;
    } tree_st_t;

    tree_st_t tr_d, tr_q;
    logic [PADW-1:0] padded;

    // Padding copies a real line, so all-one and all-zero tests are unchanged.
    for (genvar p = 0; p < PADW; p++) begin : g_pad
        if (p < W) begin : g_real
            assign padded[p] = ko_bits[p];
        end else begin : g_fill
            assign padded[p] = ko_bits[W-1];
        end
    end

    always_comb begin
        tr_d = tr_q;
        for (int g = 0; g < NGRP; g++) begin
            tr_d.grp[g] = hyst_next(&padded[g*GRP +: GRP], ~|padded[g*GRP +: GRP], tr_q.grp[g]);
        end
        tr_d.root = hyst_next(&tr_q.grp, ~|tr_q.grp, tr_q.root);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '{grp: '1, root: 1'b1};
        else        tr_q <= tr_d;
    end

    assign ko = tr_q.root;

    // R5
    ko_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_q.root && |tr_q.grp) |=> tr_q.root);
    // R5
    ko_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tr_q.root && !(&tr_q.grp)) |=> !tr_q.root);

endmodule

// File: rtl/ncl_dr_pipe.sv
module ncl_dr_pipe #(
    parameter int W   = 16,
    parameter int GRP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_t,
    input  logic [W-1:0] src_f,
    output logic         src_ko,
    output logic [W-1:0] snk_t,
    output logic [W-1:0] snk_f,
    input  logic         snk_ki
);
    logic [W-1:0] s1_t, s1_f, s1_ko;
    logic [W-1:0] mid_t, mid_f;
    logic [W-1:0] s2_ko;
    logic         ki1;

    ncl_reg_stage #(.W(W)) u_stage_in (
        .clk(clk), .rst_n(rst_n), .ki(ki1),
        .din_t(src_t), .din_f(src_f),
        .dout_t(s1_t), .dout_f(s1_f), .ko_bits(s1_ko)
    );

    ncl_compl_tree #(.W(W), .GRP(GRP)) u_cmp_in (
        .clk(clk), .rst_n(rst_n), .ko_bits(s1_ko), .ko(src_ko)
    );

    // Pass-through dual-rail datapath between the two stages.
    assign mid_t = s1_t;
    assign mid_f = s1_f;

    ncl_reg_stage #(.W(W)) u_stage_out (
        .clk(clk), .rst_n(rst_n), .ki(snk_ki),
        .din_t(mid_t), .din_f(mid_f),
        .dout_t(snk_t), .dout_f(snk_f), .ko_bits(s2_ko)
    );

    ncl_compl_tree #(.W(W), .GRP(GRP)) u_cmp_out (
        .clk(clk), .rst_n(rst_n), .ko_bits(s2_ko), .ko(ki1)
    );

    // R8
    snk_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_t & src_f)) |=> !(|(mid_t & mid_f)));

endmodule

// File: tb/tb_ncl_dr_pipe.sv
module tb_ncl_dr_pipe;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_t = '0, src_f = '0;
    logic         src_ko;
    logic [W-1:0] snk_t, snk_f;
    logic         snk_ki = 1'b1;

    int checks = 0, fails = 0;
    logic [W-1:0] expq[$];
    bit auto_sink = 1'b0;
    bit done = 1'b0;
    int delivered = 0;

    always #2.5 clk = ~clk;

    ncl_dr_pipe #(.W(W), .GRP(4)) dut (
        .clk(clk), .rst_n(rst_n), .src_t(src_t), .src_f(src_f), .src_ko(src_ko),
        .snk_t(snk_t), .snk_f(snk_f), .snk_ki(snk_ki)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit sink_full();
        return (snk_t | snk_f) == '1;
    endfunction

    function automatic bit sink_empty();
        return (snk_t | snk_f) == '0;
    endfunction

    task automatic wait_ko(input logic v);
        int n = 0;
        while (src_ko !== v && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic wait_full();
        int n = 0;
        while (!sink_full() && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic wait_empty();
        int n = 0;
        while (!sink_empty() && n < 200) begin @(negedge clk); n++; end
    endtask

    // Producer: waits for a data request, launches, waits for a null request, returns to NULL.
    task automatic launch(input logic [W-1:0] w);
        wait_ko(1'b1);
        src_t = w; src_f = ~w;
        expq.push_back(w);
        wait_ko(1'b0);
        src_t = '0; src_f = '0;
    endtask

    // Monitor: pops the scoreboard when a full word arrives.
    task automatic take(input string req);
        logic [W-1:0] e;
        e = (expq.size() > 0) ? expq.pop_front() : 'x;
        chk(req, {48'd0, snk_t}, {48'd0, e});
        delivered++;
    endtask

    initial begin : sink_proc
        logic [W-1:0] cap;
        bit bad;
        forever begin
            @(negedge clk);
            if (auto_sink && sink_full()) begin
                take("R6 word");
                cap = snk_t;
                bad = 1'b0;
                snk_ki = 1'b0;
                while (!sink_empty()) begin
                    @(negedge clk);
                    if ((snk_t & ~cap) != '0 || (snk_f & cap) != '0) bad = 1'b1;
                    if ((snk_t & snk_f) != '0) bad = 1'b1;
                end
                // R7 and R8: only captured value or NULL seen, and never both rails high
                chk("R7 R8 hold", {63'd0, bad}, 64'd0);
                snk_ki = 1'b1;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] w;
        int sent;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 rails in reset", {32'd0, snk_t, snk_f}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after reset
        chk("R1 rails", {32'd0, snk_t, snk_f}, 64'd0);
        chk("R1 ko", {63'd0, src_ko}, 64'd1);

        // R2: consumer asks for null, data must not reach the sink
        snk_ki = 1'b0;
        launch(16'hA5C3);
        repeat (20) @(negedge clk);
        chk("R2 sink stays NULL", {32'd0, snk_t, snk_f}, 64'd0);
        chk("R5 ko low after full word", {63'd0, src_ko}, 64'd0);
        snk_ki = 1'b1;
        wait_full();
        // R4: true rail carries the ones, false rail the zeros
        chk("R4 false rails", {48'd0, snk_f}, {48'd0, ~16'hA5C3});
        take("R6 first word");

        // R3: held DATA survives producer NULL while grant stays high
        repeat (20) @(negedge clk);
        chk("R3 sink holds DATA", {48'd0, snk_t}, 64'hA5C3);
        chk("R3 ko back high", {63'd0, src_ko}, 64'd1);
        snk_ki = 1'b0;
        wait_empty();
        chk("R7 NULL between words", {63'd0, sink_empty()}, 64'd1);
        snk_ki = 1'b1;

        // R5: partial DATA word keeps the request high
        src_t = 16'h003C; src_f = 16'h00C3;
        repeat (20) @(negedge clk);
        chk("R5 partial DATA holds ko", {63'd0, src_ko}, 64'd1);
        src_t = 16'h5A3C; src_f = 16'hA5C3;
        expq.push_back(16'h5A3C);
        wait_ko(1'b0);
        chk("R5 full DATA drops ko", {63'd0, src_ko}, 64'd0);
        wait_full();
        take("R6 partial-then-full word");
        snk_ki = 1'b0;
        // R5: partial NULL keeps the request low
        src_t = 16'h003C; src_f = 16'h00C3;
        repeat (20) @(negedge clk);
        chk("R5 partial NULL holds ko", {63'd0, src_ko}, 64'd0);
        src_t = '0; src_f = '0;
        wait_ko(1'b1);
        chk("R5 full NULL raises ko", {63'd0, src_ko}, 64'd1);
        wait_empty();
        snk_ki = 1'b1;

        // R6 R7: streamed words with an automatic consumer
        delivered = 0;
        auto_sink = 1'b1;
        w = 16'h1;
        sent = 0;
        for (int k = 0; k < 30; k++) begin
            case (k)
                0: launch(16'h0000);
                1: launch(16'hFFFF);
                2: launch(16'h8000);
                3: launch(16'h0001);
                default: begin
                    w = {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
                    launch(w);
                end
            endcase
            sent++;
        end
        repeat (100) @(negedge clk);
        chk("R6 delivered count", 64'(delivered), 64'(sent));
        chk("R6 scoreboard empty", 64'(expq.size()), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule